// File: doc/BRIEF.md
# Receive Holding Buffer with Break Capture

This block is the receive side of one serial channel after the deserialiser. Incoming bytes are offered on a valid/ready handshake and kept in a small circular buffer, three entries deep by default. Software or a bus adapter takes them out one at a time through a read strobe; the oldest pending byte is always visible on the read data output. The block also tells the sender how much room is left, and this figure reads zero while reception is switched off.

A separate break input represents a line break seen by the deserialiser. It records the condition in a break status bit, raises a break interrupt flag, and places a zero byte in the buffer. A read that removes a byte while break status is set moves the condition from status into the interrupt flag. A break that finds the buffer full keeps its status but loses its zero byte and raises an overrun bit. A clear input drops the break interrupt flag and the overrun bit.

The controller is a fill-state machine with three states: EMPTY, PARTIAL and FULL. Its transitions are ARRIVE (EMPTY to PARTIAL, or to FULL when the depth is one), FILL_UP (PARTIAL to FULL), DRAIN_OUT (PARTIAL or FULL to EMPTY), BACK_OFF (FULL to PARTIAL) and HOLD (no change, including a push and a read in the same cycle). A pending count and a read index run beside the state.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the buffer is empty, every status and interrupt flag is 0, read data is 0x00, and with reception enabled the free space equals the depth (3).
- R2: in_ready is high exactly when rx_en is high, fewer than 3 bytes are pending and brk_evt is low. space equals 3 minus the pending count while rx_en is high and 0 while it is low. A byte offered while in_ready is low is not stored.
- R3: Bytes leave in the order they were accepted. rd_data shows the oldest pending byte, and each rd_stb pulse with at least one byte pending removes it at the clock edge. A push and a read in the same cycle leave the pending count unchanged and keep the order.
- R4: st_rx_ready and irq_rx_ready go high in the cycle after a byte is stored into an empty buffer. They go low in the cycle after the last pending byte is read, unless a new byte is stored in that same cycle.
- R5: st_fifo_full is high exactly when 3 bytes are pending.
- R6: An rd_stb pulse with nothing pending changes no state. rd_data keeps showing the byte that was read last.
- R7: A brk_evt pulse sets st_break in the next cycle, sets irq_break if st_break was clear, and stores a 0x00 byte if the buffer is not full. This happens even while rx_en is low.
- R8: An rd_stb that removes a byte while st_break is set clears st_break and sets irq_break in the next cycle, unless brk_evt is high in the same cycle, in which case st_break stays set.
- R9: A brk_evt that finds 3 bytes pending stores nothing, even if a read happens in the same cycle, and sets st_overrun in the next cycle.
- R10: An err_clear pulse clears irq_break and st_overrun in the next cycle. A set of either flag in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enable level |
| in_valid | input | 1 | Sender offers a byte |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Buffer takes the offered byte this cycle |
| space | output | 2 | Free entries offered to the sender |
| brk_evt | input | 1 | Line break event pulse |
| rd_stb | input | 1 | Holding-register read strobe |
| rd_data | output | 8 | Byte at the read index |
| err_clear | input | 1 | Clears break interrupt and overrun |
| st_rx_ready | output | 1 | Status: at least one byte pending |
| st_fifo_full | output | 1 | Status: buffer full |
| st_break | output | 1 | Status: break seen, not yet consumed |
| st_overrun | output | 1 | Status: break zero byte lost to a full buffer |
| irq_rx_ready | output | 1 | Receive-ready interrupt flag |
| irq_break | output | 1 | Break interrupt flag |

## Verification
The hardest case to reach from the ports is the hand-off in R8, where st_break is set but irq_break is already clear, so that only the consuming read can raise the flag. The bench builds it on purpose: it injects a break while reception is off, clears the interrupt with err_clear, and only then reads the zero byte. A full buffer that meets a break, and a push together with a read on a single pending byte, are also driven directly. Long random runs with frequent reads, rare breaks and occasional clears then mix all of these cases.

// File: rtl/rx_hold_pkg.sv
package rx_hold_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_e;
endpackage

// File: rtl/rx_hold_store.sv
module rx_hold_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = slot[i];
            end
        end
    end
endmodule

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl
    import rx_hold_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int IDX_W = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             in_valid,
    input  logic             brk_evt,
    input  logic             rd_stb,
    output logic             in_ready,
    output logic             take,
    output logic             consume,
    output logic             full,
    output logic             drained,
    output logic [CNT_W-1:0] space,
    output logic [CNT_W-1:0] cnt,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] wr_idx
);
    localparam int               SUM_W   = CNT_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [SUM_W-1:0] DEPTH_S = SUM_W'(DEPTH);
    localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(DEPTH - 1);

    fill_e            state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [SUM_W-1:0] slot_sum;
    logic             empty;

    assign full     = (state_q == FILL_FULL);
    assign empty    = (state_q == FILL_EMPTY);
    assign in_ready = rx_en && !full && !brk_evt;
    assign take     = brk_evt ? !full : (in_valid && in_ready);
    assign consume  = rd_stb && !empty;
    assign space    = rx_en ? (DEPTH_C - cnt_q) : '0;
    assign cnt      = cnt_q;
    assign rd_idx   = idx_q;
    assign slot_sum = SUM_W'(idx_q) + SUM_W'(cnt_q);
    assign wr_idx   = (slot_sum >= DEPTH_S) ? IDX_W'(slot_sum - DEPTH_S) : IDX_W'(slot_sum);
    assign drained  = (cnt_d == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (take && !consume) begin
            cnt_d = cnt_q + 1'b1;
        end else if (consume && !take) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_comb begin
        idx_d = idx_q;
        if (consume && !drained) begin
            idx_d = (idx_q == LAST_I) ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (take) begin
                    state_d = (cnt_d == DEPTH_C) ? FILL_FULL : FILL_PARTIAL;
                end
            end
            FILL_PARTIAL: begin
                if (drained) begin
                    state_d = FILL_EMPTY;
                end else if (cnt_d == DEPTH_C) begin
                    state_d = FILL_FULL;
                end
            end
            FILL_FULL: begin
                if (consume) begin
                    state_d = drained ? FILL_EMPTY : FILL_PARTIAL;
                end
            end
            default: state_d = FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end
endmodule

// File: rtl/rx_hold_flags.sv
module rx_hold_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic consume,
    input  logic drained,
    input  logic full,
    input  logic brk_evt,
    input  logic err_clear,
    output logic rdy,
    output logic irq_rx,
    output logic brk,
    output logic irq_brk,
    output logic ovr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy     <= 1'b0;
            irq_rx  <= 1'b0;
            brk     <= 1'b0;
            irq_brk <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (take && !rdy) begin
                rdy    <= 1'b1;
                irq_rx <= 1'b1;
            end else if (consume && drained) begin
                rdy    <= 1'b0;
                irq_rx <= 1'b0;
            end

            if (brk_evt) begin
                brk <= 1'b1;
            end else if (consume && brk) begin
                brk <= 1'b0;
            end

            if ((brk_evt && !brk) || (consume && brk)) begin
                irq_brk <= 1'b1;
            end else if (err_clear) begin
                irq_brk <= 1'b0;
            end

            if (brk_evt && full) begin
                ovr <= 1'b1;
            end else if (err_clear) begin
                ovr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic [CNT_W-1:0]  space,
    input  logic              brk_evt,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    input  logic              err_clear,
    output logic              st_rx_ready,
    output logic              st_fifo_full,
    output logic              st_break,
    output logic              st_overrun,
    output logic              irq_rx_ready,
    output logic              irq_break
);
    logic             take, consume, full, drained;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [DATA_W-1:0] wr_data;

    assign wr_data      = brk_evt ? '0 : in_data;
    assign st_fifo_full = full;

    rx_hold_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .brk_evt(brk_evt), .rd_stb(rd_stb), .in_ready(in_ready),
        .take(take), .consume(consume), .full(full), .drained(drained),
        .space(space), .cnt(cnt), .rd_idx(rd_idx), .wr_idx(wr_idx)
    );

    rx_hold_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(take), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    rx_hold_flags u_flags (
        .clk(clk), .rst_n(rst_n), .take(take), .consume(consume),
        .drained(drained), .full(full), .brk_evt(brk_evt),
        .err_clear(err_clear), .rdy(st_rx_ready), .irq_rx(irq_rx_ready),
        .brk(st_break), .irq_brk(irq_break), .ovr(st_overrun)
    );
endmodule

// File: rtl/rx_hold_chk.sv
module rx_hold_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              in_valid,
    input logic              in_ready,
    input logic [CNT_W-1:0]  space,
    input logic              brk_evt,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              st_rx_ready,
    input logic              st_fifo_full,
    input logic              st_break,
    input logic              st_overrun,
    input logic              irq_rx_ready,
    input logic              irq_break,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> (space == '0 && !in_ready));

    p_ready_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_rx_ready == (cnt != '0));

    p_irq_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx_ready == st_rx_ready);

    p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_fifo_full |-> (cnt == DEPTH_C && !in_ready));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && cnt == '0 && !brk_evt && !(in_valid && in_ready))
        |=> ($stable(rd_data) && cnt == '0));

    p_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> st_break);

    p_brk_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && cnt != '0 && st_break && !brk_evt) |=> (!st_break && irq_break));

    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_evt && st_fifo_full) |=> st_overrun);
endmodule

bind rx_hold_fifo rx_hold_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
    .in_ready(in_ready), .space(space), .brk_evt(brk_evt), .rd_stb(rd_stb),
    .rd_data(rd_data), .st_rx_ready(st_rx_ready), .st_fifo_full(st_fifo_full),
    .st_break(st_break), .st_overrun(st_overrun), .irq_rx_ready(irq_rx_ready),
    .irq_break(irq_break), .cnt(cnt)
);

// File: tb/rx_hold_fifo_test.sv
`timescale 1ns/1ps
module rx_hold_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, in_valid = 1'b0, brk_evt = 1'b0, rd_stb = 1'b0, err_clear = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic [1:0] space;
    logic [7:0] rd_data;
    logic       st_rx_ready, st_fifo_full, st_break, st_overrun, irq_rx_ready, irq_break;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] mb [3];
    int mi, mc;
    bit mr, mbk, mib, mo;

    always #10 clk = ~clk;

    rx_hold_fifo uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .space(space),
        .brk_evt(brk_evt), .rd_stb(rd_stb), .rd_data(rd_data),
        .err_clear(err_clear), .st_rx_ready(st_rx_ready),
        .st_fifo_full(st_fifo_full), .st_break(st_break),
        .st_overrun(st_overrun), .irq_rx_ready(irq_rx_ready),
        .irq_break(irq_break)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_space(input bit en);
        return en ? (3 - mc) : 0;
    endfunction

    task automatic cycle(input bit en, input bit v, input logic [7:0] d,
                         input bit rd, input bit bk, input bit clr);
        bit rdy_exp, tk, cs;
        int cn;
        logic [7:0] wd;
        @(negedge clk);
        rx_en = en; in_valid = v; in_data = d; rd_stb = rd; brk_evt = bk; err_clear = clr;
        #2;
        rdy_exp = en && (mc < 3) && !bk;
        chk("R2 in_ready", in_ready, rdy_exp);
        chk("R2 space", space, exp_space(en));
        chk("R3 rd_data", rd_data, mb[mi]);
        tk = bk ? (mc < 3) : (v && rdy_exp);
        cs = rd && (mc != 0);
        wd = bk ? 8'h00 : d;
        cn = mc + (tk ? 1 : 0) - (cs ? 1 : 0);
        @(posedge clk);
        #2;
        if (tk) mb[(mi + mc) % 3] = wd;
        if (cs && cn != 0) mi = (mi + 1) % 3;
        if (tk && !mr) mr = 1'b1;
        else if (cs && cn == 0) mr = 1'b0;
        if ((bk && !mbk) || (cs && mbk)) mib = 1'b1;
        else if (clr) mib = 1'b0;
        if (bk && mc == 3) mo = 1'b1;
        else if (clr) mo = 1'b0;
        if (bk) mbk = 1'b1;
        else if (cs && mbk) mbk = 1'b0;
        mc = cn;
        chk("R4 st_rx_ready", st_rx_ready, mr);
        chk("R4 irq_rx_ready", irq_rx_ready, mr);
        chk("R5 st_fifo_full", st_fifo_full, mc == 3);
        chk("R7 st_break", st_break, mbk);
        chk("R8 irq_break", irq_break, mib);
        chk("R9 st_overrun", st_overrun, mo);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] seen;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 3; i++) mb[i] = 8'h00;
        mi = 0; mc = 0; mr = 0; mbk = 0; mib = 0; mo = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; rx_en = 1'b1;
        #2;
        // R1: reset state
        chk("R1 space", space, 3);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 flags", {st_rx_ready, st_fifo_full, st_break, st_overrun, irq_rx_ready, irq_break}, 0);

        // R3/R5: fill to three, then an extra offer is refused (R2)
        cycle(1, 1, 8'hA1, 0, 0, 0);
        cycle(1, 1, 8'hB2, 0, 0, 0);
        cycle(1, 1, 8'hC3, 0, 0, 0);
        chk("R5 full after three", st_fifo_full, 1);
        cycle(1, 1, 8'hD4, 0, 0, 0);
        chk("R2 refused byte, space", space, 0);

        // R9: break into full buffer
        cycle(1, 0, 8'h00, 0, 1, 0);
        chk("R9 overrun set", st_overrun, 1);
        chk("R9 break recorded", st_break, 1);

        // R3: drain in order
        #1 seen = rd_data; chk("R3 first out", seen, 8'hA1);
        cycle(1, 0, 8'h00, 1, 0, 0);
        #1 seen = rd_data; chk("R3 second out", seen, 8'hB2);
        cycle(1, 0, 8'h00, 1, 0, 0);
        #1 seen = rd_data; chk("R3 third out", seen, 8'hC3);
        cycle(1, 0, 8'h00, 1, 0, 0);
        chk("R4 ready dropped", st_rx_ready, 0);

        // R6: empty read leaves state
        cycle(1, 0, 8'h00, 1, 0, 0);
        chk("R6 stale data", rd_data, 8'hC3);
        chk("R6 space", space, 3);

        // R10: clear
        cycle(1, 0, 8'h00, 0, 0, 1);
        chk("R10 irq_break cleared", irq_break, 0);
        chk("R10 overrun cleared", st_overrun, 0);

        // R7: break with reception off; offered byte ignored (R2)
        cycle(0, 1, 8'h77, 0, 1, 0);
        cycle(0, 1, 8'h66, 0, 0, 0);
        chk("R7 zero byte stored", rd_data, 8'h00);
        chk("R7 ready", st_rx_ready, 1);
        chk("R2 disabled space", space, 0);

        // R8: clear the irq, then the consuming read hands break over
        cycle(0, 0, 8'h00, 0, 0, 1);
        chk("R8 pre irq clear", irq_break, 0);
        cycle(0, 0, 8'h00, 1, 0, 0);
        chk("R8 break status cleared", st_break, 0);
        chk("R8 irq raised by read", irq_break, 1);

        // R3/R4: push and read together on one pending byte
        cycle(1, 1, 8'h11, 0, 0, 0);
        cycle(1, 1, 8'h22, 1, 0, 0);
        chk("R4 ready held", st_rx_ready, 1);
        chk("R3 next byte", rd_data, 8'h22);

        // R10: set beats clear
        cycle(1, 0, 8'h00, 0, 1, 1);
        chk("R10 set wins", irq_break, 1);

        for (int n = 0; n < 4000; n++) begin
            bit en, v, rd, bk, clr;
            en  = ($urandom % 8) != 0;
            v   = ($urandom % 2) != 0;
            rd  = ($urandom % 5) < 2;
            bk  = ($urandom % 20) == 0;
            clr = ($urandom % 10) == 0;
            cycle(en, v, 8'($urandom), rd, bk, clr);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule